// File: doc/BRIEF.md
# Multi-Format Audio Sample Converter

This block turns audio samples for one conversion channel from one encoding into another, in both directions. On the receive side, a 16-bit sample field taken from a serial port is expanded into a 16-bit two's-complement linear value for internal use. On the transmit side, a 16-bit linear value is compressed or reduced into the 16-bit field format that goes out of the port. A 2-bit format select picks one of four encodings: 16-bit linear, 8-bit unsigned linear, 8-bit mu-law or 8-bit A-law.

All 8-bit encodings occupy the upper byte of the 16-bit field, so full scale means the same level in every format. Companded codes expand to a 14-bit (mu-law) or 13-bit (A-law) value, and that value is placed in the top bits of the internal word. Each direction is combinational logic followed by a single register stage with a valid flag. One instance serves one channel, so each channel can use its own format. The format select is sampled together with each valid sample, and applies to both directions in that cycle.

Top module: `pcmFormatConv`

## Requirements
- R1: While reset (`rstN` low) is asserted, and at the first sample point after it is released, `expandValid` and `compressValid` are 0 and `expandLinear` and `compressField` are 0.
- R2: A sample presented with `rxValid` (or `txValid`) high at a rising clock edge appears with `expandValid` (or `compressValid`) high after exactly that one edge. In a cycle without an input valid, the matching output valid is 0 and the data output holds its previous value.
- R3: Format code 0 selects 16-bit linear, and both directions pass the 16 bits through unchanged.
- R4: Format code 1 selects unsigned 8-bit. Expansion yields the top byte with bit 15 inverted, followed by eight zero bits.
- R5: With format code 1, compression outputs linear bits 15..8 with bit 15 inverted as the field's top byte. The lower linear bits are dropped.
- R6: For format codes 1, 2 and 3, bits 7..0 of `rxField` have no effect on `expandLinear`.
- R7: For format codes 1, 2 and 3, bits 7..0 of `compressField` are 0.
- R8: Format code 2 selects mu-law. The code byte is inverted to give sign s (bit 7, 1 means negative), segment e (bits 6..4) and mantissa m (bits 3..0). The magnitude is ((2m+33)<<e)-33. The signed 14-bit result is placed in bits 15..2 of `expandLinear`, and bits 1..0 are 0.
- R9: For mu-law compression, v is linear bits 15..2 taken as signed. The encoder computes b = |v|+33, limited to 8191. e is the index of the highest set bit of b minus 5, and m = (b>>(e+1)) mod 16. The output byte is the inverse of {v<0, e, m}, so out-of-range inputs saturate to the top segment.
- R10: Format code 3 selects A-law. The code byte is XORed with 0x55 to give a positive flag p (bit 7, 1 means positive), e (bits 6..4) and m (bits 3..0). The magnitude is 2m+1 when e=0, and (2m+33)<<(e-1) otherwise. The signed 13-bit result is placed in bits 15..3 of `expandLinear`, and bits 2..0 are 0.
- R11: For A-law compression, v is linear bits 15..3 taken as signed, and a = |v| limited to 4095. If a<32, then e=0 and m=a>>1. Otherwise e is the index of the highest set bit of a minus 4, and m = (a>>e) mod 16. The output byte is {v>=0, e, m} XOR 0x55.
- R12: The format select is sampled with each valid sample, so consecutive samples in different formats are each converted by their own format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fmtSel | input | 2 | Format: 0 linear16, 1 unsigned8, 2 mu-law, 3 A-law |
| rxValid | input | 1 | Received field present this cycle |
| rxField | input | 16 | Received port field |
| txValid | input | 1 | Linear sample to transmit present this cycle |
| txLinear | input | 16 | Linear sample to transmit |
| expandValid | output | 1 | Expanded sample valid |
| expandLinear | output | 16 | Expanded linear sample |
| compressValid | output | 1 | Compressed field valid |
| compressField | output | 16 | Compressed port field |

## Verification
The hardest cases to reach from the ports are the extremes of the companding curves. These include the clip point where the biased mu-law magnitude passes 8191, the most negative codes (0x8000) whose magnitude does not fit the signed width, and the boundary between A-law segment 0 and segment 1 at magnitude 32. Uniform random linear inputs almost never land on these values, so directed samples place inputs on each segment edge and at both full-scale ends, in both directions. A randomized run then switches format on every sample, with random gaps between samples, so that the hold and format-sampling behaviour is also exercised.

// File: rtl/pcmFmtPkg.sv
package pcmFmtPkg;
  typedef enum logic [1:0] {
    FMT_LIN16 = 2'd0,
    FMT_UNS8  = 2'd1,
    FMT_MULAW = 2'd2,
    FMT_ALAW  = 2'd3
  } sampleFmt_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capRx;
    logic capTx;
  } convStrobe_t;
endpackage

// File: rtl/pcmExpander.sv
module pcmExpander
  import pcmFmtPkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int CODE_W  = 8
) (
  input  sampleFmt_e         fmt,
  input  logic [FIELD_W-1:0] field,
  output logic [FIELD_W-1:0] lin
);
  localparam int MU_W   = 14;
  localparam int A_W    = 13;
  localparam int A_MW   = A_W - 1;
  localparam int MU_PAD = FIELD_W - MU_W;
  localparam int A_PAD  = FIELD_W - A_W;
  localparam int LO_W   = FIELD_W - CODE_W;

  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] muRaw;
  logic [CODE_W-1:0] aRaw;
  logic [2:0]        muSeg, aSeg;
  logic [3:0]        muMant, aMant;
  logic [MU_W-1:0]   muBase, muMag, muVal;
  logic [A_MW-1:0]   aBase, aMag;
  logic [A_W-1:0]    aVal;

  assign code = field[FIELD_W-1 -: CODE_W];

  // mu-law: bits inverted, biased segment decode
  always_comb begin
    muRaw  = ~code;
    muSeg  = muRaw[6:4];
    muMant = muRaw[3:0];
    muBase = MU_W'({muMant, 1'b0}) + MU_W'(33);
    muMag  = (muBase << muSeg) - MU_W'(33);
    muVal  = muRaw[7] ? (~muMag + MU_W'(1)) : muMag;
  end

  // A-law: even bits toggled, linear first segment
  always_comb begin
    aRaw  = code ^ 8'h55;
    aSeg  = aRaw[6:4];
    aMant = aRaw[3:0];
    aBase = A_MW'({aMant, 1'b0}) + A_MW'(33);
    if (aSeg == 3'd0) aMag = A_MW'({aMant, 1'b1});
    else              aMag = aBase << (aSeg - 3'd1);
    aVal = aRaw[7] ? {1'b0, aMag} : (~{1'b0, aMag} + A_W'(1));
  end

  always_comb begin
    case (fmt)
      FMT_LIN16: lin = field;
      FMT_UNS8:  lin = {~code[CODE_W-1], code[CODE_W-2:0], {LO_W{1'b0}}};
      FMT_MULAW: lin = {muVal, {MU_PAD{1'b0}}};
      default:   lin = {aVal, {A_PAD{1'b0}}};
    endcase
  end
endmodule

// File: rtl/pcmCompressor.sv
module pcmCompressor
  import pcmFmtPkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int CODE_W  = 8
) (
  input  sampleFmt_e         fmt,
  input  logic [FIELD_W-1:0] lin,
  output logic [FIELD_W-1:0] field
);
  localparam int MU_W    = 14;
  localparam int A_W     = 13;
  localparam int MU_CW   = MU_W - 1;
  localparam int A_MW    = A_W - 1;
  localparam int LO_W    = FIELD_W - CODE_W;
  localparam int MU_CLIP = (1 << MU_CW) - 1;
  localparam int A_CLIP  = (1 << A_MW) - 1;

  logic [MU_W-1:0]  xMu;
  logic [A_W-1:0]   xA;
  logic             muNeg, aNeg;
  logic [MU_W:0]    muMag, muBiased;
  logic [MU_CW-1:0] muClip;
  logic [A_W-1:0]   aMagW;
  logic [A_MW-1:0]  aClip;
  logic [2:0]       muSeg, aSeg;
  logic [3:0]       muMant, aMant;
  logic [CODE_W-1:0] muCode, aCode, uCode;

  assign xMu = lin[FIELD_W-1 -: MU_W];
  assign xA  = lin[FIELD_W-1 -: A_W];

  // mu-law encoder
  always_comb begin
    muNeg    = xMu[MU_W-1];
    muMag    = muNeg ? ({1'b0, ~xMu} + (MU_W+1)'(1)) : {1'b0, xMu};
    muBiased = muMag + (MU_W+1)'(33);
    muClip   = (muBiased > (MU_W+1)'(MU_CLIP)) ? MU_CW'(MU_CLIP) : muBiased[MU_CW-1:0];
    muSeg    = 3'd0;
    for (int i = 1; i < 8; i++) begin
      if (muClip[i+5]) muSeg = 3'(i);
    end
    muMant = 4'(muClip >> (4'(muSeg) + 4'd1));
    muCode = ~{muNeg, muSeg, muMant};
  end

  // A-law encoder
  always_comb begin
    aNeg  = xA[A_W-1];
    aMagW = aNeg ? (~xA + A_W'(1)) : xA;
    aClip = (aMagW > A_W'(A_CLIP)) ? A_MW'(A_CLIP) : aMagW[A_MW-1:0];
    aSeg  = 3'd0;
    for (int i = 1; i < 8; i++) begin
      if (aClip[i+4]) aSeg = 3'(i);
    end
    if (aSeg == 3'd0) aMant = aClip[4:1];
    else              aMant = 4'(aClip >> aSeg);
    aCode = {~aNeg, aSeg, aMant} ^ 8'h55;
  end

  assign uCode = {~lin[FIELD_W-1], lin[FIELD_W-2 -: CODE_W-1]};

  always_comb begin
    case (fmt)
      FMT_LIN16: field = lin;
      FMT_UNS8:  field = {uCode, {LO_W{1'b0}}};
      FMT_MULAW: field = {muCode, {LO_W{1'b0}}};
      default:   field = {aCode, {LO_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/pcmConvCtrl.sv
module pcmConvCtrl
  import pcmFmtPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        txValid,
  output convStrobe_t strobe,
  output logic        expandValid,
  output logic        compressValid
);
  always_comb begin
    strobe.capRx = rxValid;
    strobe.capTx = txValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expandValid   <= 1'b0;
      compressValid <= 1'b0;
    end else begin
      expandValid   <= rxValid;
      compressValid <= txValid;
    end
  end
endmodule

// File: rtl/pcmConvPath.sv
module pcmConvPath
  import pcmFmtPkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  sampleFmt_e         fmt,
  input  convStrobe_t        strobe,
  input  logic [FIELD_W-1:0] rxField,
  input  logic [FIELD_W-1:0] txLinear,
  output logic [FIELD_W-1:0] expandLinear,
  output logic [FIELD_W-1:0] compressField
);
  logic [FIELD_W-1:0] expNext, cmpNext;

  pcmExpander #(.FIELD_W(FIELD_W), .CODE_W(CODE_W)) uExp (
    .fmt(fmt), .field(rxField), .lin(expNext)
  );

  pcmCompressor #(.FIELD_W(FIELD_W), .CODE_W(CODE_W)) uCmp (
    .fmt(fmt), .lin(txLinear), .field(cmpNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expandLinear  <= '0;
      compressField <= '0;
    end else begin
      if (strobe.capRx) expandLinear  <= expNext;
      if (strobe.capTx) compressField <= cmpNext;
    end
  end
endmodule

// File: rtl/pcmFormatConv.sv
module pcmFormatConv
  import pcmFmtPkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         fmtSel,
  input  logic               rxValid,
  input  logic [FIELD_W-1:0] rxField,
  input  logic               txValid,
  input  logic [FIELD_W-1:0] txLinear,
  output logic               expandValid,
  output logic [FIELD_W-1:0] expandLinear,
  output logic               compressValid,
  output logic [FIELD_W-1:0] compressField
);
  convStrobe_t strobe;

  pcmConvCtrl uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .txValid(txValid),
    .strobe(strobe), .expandValid(expandValid), .compressValid(compressValid)
  );

  pcmConvPath #(.FIELD_W(FIELD_W), .CODE_W(CODE_W)) uPath (
    .clk(clk), .rstN(rstN), .fmt(sampleFmt_e'(fmtSel)), .strobe(strobe),
    .rxField(rxField), .txLinear(txLinear),
    .expandLinear(expandLinear), .compressField(compressField)
  );
endmodule

// File: rtl/pcmFormatConvChk.sv
module pcmFormatConvChk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  fmtSel,
  input logic        rxValid,
  input logic [15:0] rxField,
  input logic        txValid,
  input logic [15:0] txLinear,
  input logic        expandValid,
  input logic [15:0] expandLinear,
  input logic        compressValid,
  input logic [15:0] compressField
);
  AST_RX_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> expandValid);  // R2
  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> (!expandValid && $stable(expandLinear)));  // R2
  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |=> (!compressValid && $stable(compressField)));  // R2
  AST_LIN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && fmtSel == 2'd0) |=> (compressField == $past(txLinear)));  // R3
  AST_UNS_EXPAND: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && fmtSel == 2'd1) |=> (expandLinear[15] != $past(rxField[15]) && expandLinear[7:0] == 8'h00));  // R4
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && fmtSel != 2'd0) |=> (compressField[7:0] == 8'h00));  // R7
  AST_MU_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && fmtSel == 2'd2) |=> (expandLinear[1:0] == 2'b00));  // R8
  AST_A_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && fmtSel == 2'd3) |=> (expandLinear[2:0] == 3'b000));  // R10
endmodule

bind pcmFormatConv pcmFormatConvChk uChk (
  .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .rxValid(rxValid), .rxField(rxField),
  .txValid(txValid), .txLinear(txLinear), .expandValid(expandValid),
  .expandLinear(expandLinear), .compressValid(compressValid),
  .compressField(compressField)
);

// File: tb/sim_pcmFormatConv.sv
module sim_pcmFormatConv;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_STEPS = 3000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  fmtSel;
  logic        rxValid, txValid;
  logic [15:0] rxField, txLinear;
  logic        expandValid, compressValid;
  logic [15:0] expandLinear, compressField;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;
  logic [15:0] holdRx = 16'h0;
  logic [15:0] holdTx = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcmFormatConv u0 (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .rxValid(rxValid), .rxField(rxField),
    .txValid(txValid), .txLinear(txLinear), .expandValid(expandValid),
    .expandLinear(expandLinear), .compressValid(compressValid),
    .compressField(compressField)
  );

  function automatic logic [15:0] refExpand(logic [1:0] f, logic [15:0] d);
    logic [7:0] c;
    int s, m, mag, v;
    case (f)
      2'd0: return d;
      2'd1: return {~d[15], d[14:8], 8'h00};
      2'd2: begin
        c = ~d[15:8]; s = c[6:4]; m = c[3:0];
        mag = ((2*m + 33) << s) - 33;
        v = c[7] ? -mag : mag;
        return 16'(v * 4);
      end
      default: begin
        c = d[15:8] ^ 8'h55; s = c[6:4]; m = c[3:0];
        mag = (s == 0) ? (2*m + 1) : ((2*m + 33) << (s - 1));
        v = c[7] ? mag : -mag;
        return 16'(v * 8);
      end
    endcase
  endfunction

  function automatic logic [15:0] refCompress(logic [1:0] f, logic [15:0] d);
    int v, mag, b, s, m, neg, code;
    case (f)
      2'd0: return d;
      2'd1: return {~d[15], d[14:8], 8'h00};
      2'd2: begin
        v = $signed(d); v = v >>> 2;
        neg = (v < 0) ? 1 : 0;
        mag = neg ? -v : v;
        b = mag + 33; if (b > 8191) b = 8191;
        s = 0; while (b >= (64 << s)) s++;
        m = (b >> (s + 1)) & 15;
        code = ~((neg << 7) | (s << 4) | m) & 255;
        return {8'(code), 8'h00};
      end
      default: begin
        v = $signed(d); v = v >>> 3;
        neg = (v < 0) ? 1 : 0;
        mag = neg ? -v : v;
        if (mag > 4095) mag = 4095;
        if (mag < 32) begin s = 0; m = mag >> 1; end
        else begin
          s = 1; while (mag >= (32 << s)) s++;
          m = (mag >> s) & 15;
        end
        code = ((((neg != 0) ? 0 : 1) << 7) | (s << 4) | m) ^ 8'h55;
        return {8'(code), 8'h00};
      end
    endcase
  endfunction

  function automatic string rxTag(logic [1:0] f);
    case (f) 2'd0: return "R3"; 2'd1: return "R4"; 2'd2: return "R8"; default: return "R10"; endcase
  endfunction

  function automatic string txTag(logic [1:0] f);
    case (f) 2'd0: return "R3"; 2'd1: return "R5"; 2'd2: return "R9"; default: return "R11"; endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drives, waits one edge, checks at the next falling edge
  task automatic step(bit rv, logic [1:0] f, logic [15:0] rf, bit tv, logic [15:0] tl, string extraTag);
    logic [15:0] eRx, eTx;
    rxValid = rv; txValid = tv; fmtSel = f; rxField = rf; txLinear = tl;
    eRx = rv ? refExpand(f, rf) : holdRx;
    eTx = tv ? refCompress(f, tl) : holdTx;
    @(negedge clk);
    chk(expandValid == rv, "R2", 16'(expandValid), 16'(rv));
    chk(compressValid == tv, "R2", 16'(compressValid), 16'(tv));
    chk(expandLinear == eRx, rv ? {rxTag(f), extraTag} : "R2", expandLinear, eRx);
    chk(compressField == eTx, tv ? {txTag(f), extraTag} : "R2", compressField, eTx);
    if (tv && f != 2'd0) chk(compressField[7:0] == 8'h00, "R7", compressField, eTx);
    holdRx = eRx; holdTx = eTx;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [15:0] firstOut;
    logic [15:0] edgeVals [0:13];
    void'($urandom(32'h1ABC5));
    rstN = 1'b0; fmtSel = 2'd0; rxValid = 1'b0; txValid = 1'b0;
    rxField = 16'h0; txLinear = 16'h0;
    repeat (3) @(negedge clk);
    chk(expandValid == 1'b0 && compressValid == 1'b0, "R1", 16'({expandValid, compressValid}), 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(expandLinear == 16'h0, "R1", expandLinear, 16'h0);
    chk(compressField == 16'h0, "R1", compressField, 16'h0);
    chk(expandValid == 1'b0 && compressValid == 1'b0, "R1", 16'({expandValid, compressValid}), 16'h0);

    // Directed corners: full scale, zero, segment edges
    edgeVals = '{16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF, 16'h0004, 16'hFFFC,
                 16'h0100, 16'hFF00, 16'h0080, 16'h0078, 16'h7E00, 16'h8200,
                 16'h00F8, 16'h0108};
    for (int i = 0; i < 14; i++) begin
      for (int f = 0; f < 4; f++) step(1'b1, 2'(f), edgeVals[i], 1'b1, edgeVals[i], "");
    end
    // Every code byte in each companded / unsigned format
    for (int c = 0; c < 256; c++) begin
      for (int f = 1; f < 4; f++) step(1'b1, 2'(f), {8'(c), 8'h00}, 1'b1, {8'(c), 8'(c)}, "");
    end

    // R6: low byte of input ignored in 8-bit formats
    for (int f = 1; f < 4; f++) begin
      step(1'b1, 2'(f), 16'hA5_00, 1'b0, 16'h0, "_R6");
      firstOut = expandLinear;
      step(1'b1, 2'(f), 16'hA5_FF, 1'b0, 16'h0, "_R6");
      chk(expandLinear == firstOut, "R6", expandLinear, firstOut);
      step(1'b1, 2'(f), 16'hA5_3C, 1'b0, 16'h0, "_R6");
      chk(expandLinear == firstOut, "R6", expandLinear, firstOut);
    end

    // R12: format changes on back-to-back samples
    for (int k = 0; k < 8; k++) step(1'b1, 2'(k % 4), 16'h9C4E, 1'b1, 16'h9C4E, "_R12");
    for (int k = 0; k < 8; k++) step(1'b1, 2'(3 - (k % 4)), 16'h3B71, 1'b1, 16'h3B71, "_R12");

    // R2: gaps hold the previous outputs
    step(1'b0, 2'd2, 16'h1234, 1'b0, 16'h5678, "");
    step(1'b0, 2'd1, 16'hFFFF, 1'b0, 16'h0000, "");

    // Random mix
    for (int n = 0; n < RAND_STEPS; n++) begin
      step(($urandom % 4) != 0, 2'($urandom), 16'($urandom), ($urandom % 4) != 0, 16'($urandom), "");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule